// File: doc/BRIEF.md
# Word and Unsigned-Byte Load/Store Address Generator

This block turns one word or unsigned-byte load/store instruction into the address the memory access uses and the value the base register receives on writeback. It decodes the 32-bit instruction word itself. It takes the base register value and a 32-bit index value that an external shifter has already scaled. It also takes a condition-passed flag from the condition logic. The result is registered once, so all outputs appear one clock after the instruction is presented with `in_valid`.

Three offset sources are handled: a zero-extended 12-bit immediate from the instruction, a plain register, and a scaled register. Each can be used in three indexing forms. Offset form uses the computed address and keeps the base. Pre-indexed form uses the computed address and writes it back. Post-indexed form uses the untouched base as the address and writes back base plus or minus the offset. The block also flags the translated (user-privilege) post-indexed variants and marks operand combinations whose result is architecturally undefined.

Top module: `lsu_agen`

## Requirements
- R1: Bit 23 of the instruction selects the arithmetic: when it is 1 the sum is base + offset, and when it is 0 the sum is base - offset.
- R2: Offset form (bit 24 = 1, bit 21 = 0) drives `addr` with the sum and never asserts `wb_en`, whether or not the condition passes.
- R3: Pre-indexed form (bit 24 = 1, bit 21 = 1) drives `addr` with the sum. When `cond_pass` is 1 it asserts `wb_en` with `wb_val` equal to the sum.
- R4: Post-indexed form (bit 24 = 0) drives `addr` with the unmodified base. When `cond_pass` is 1 it asserts `wb_en` with `wb_val` equal to the sum.
- R5: When `cond_pass` is 0, `wb_en` is 0 one cycle later in every form.
- R6: `is_byte` follows bit 22 (1 = unsigned byte, 0 = word), and `is_load` follows bit 20 (1 = load, 0 = store).
- R7: Bit 25 selects the offset source. When it is 0, the offset is instruction bits 11:0 zero-extended. When it is 1, the offset is `index_val`.
- R8: A post-indexed encoding with bit 21 = 1 asserts `user_xlat`, and it still performs post-index writeback under R4. No other form asserts `user_xlat`.
- R9: `unpred` is 1 when any of these holds for a recognised instruction: Rn (bits 19:16) is 15 in a writeback form (pre- or post-indexed); Rm (bits 3:0) is 15 in a register-offset form; or Rn equals Rm in a register-offset writeback form. Otherwise `unpred` is 0.
- R10: All address arithmetic wraps modulo 2^32.
- R11: While `rst_n` is low, every output is 0.
- R12: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is 0, the next cycle has `wb_en` equal to 0.
- R13: An instruction is recognised only when bits 27:26 are 01, and not when bit 25 and bit 4 are both 1. `hit` reports recognition. For an unrecognised instruction, `wb_en`, `user_xlat` and `unpred` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction and operands are presented this cycle |
| instr | input | 32 | Instruction word |
| base_val | input | DATA_W | Base register (Rn) value |
| index_val | input | DATA_W | Index register value after the external shifter |
| cond_pass | input | 1 | Condition check passed for this instruction |
| out_valid | output | 1 | Registered result is valid |
| hit | output | 1 | Instruction belongs to this load/store class |
| addr | output | DATA_W | Memory access address |
| wb_en | output | 1 | Write `wb_val` back to the base register |
| wb_val | output | DATA_W | Updated base value |
| is_load | output | 1 | 1 = load, 0 = store |
| is_byte | output | 1 | 1 = unsigned byte, 0 = word |
| user_xlat | output | 1 | Translated (user-privilege) access |
| unpred | output | 1 | Operand combination has undefined result |

## Verification
The bench builds the block with `DATA_W = 32` and with `SHARED_ADDER = 1`. That is the default, single-adder variant, in which subtraction reuses the adder through an inverted operand and a carry-in. The 32-bit width puts the modulo-2^32 wrap within reach of directed vectors on both the add and the subtract path. The random vectors cover every combination of bits 25, 24, 23 and 21 together with the condition flag. They also include register numbers biased toward 15 and toward Rn equal to Rm, so that each clause of the undefined-result flag is hit.

// File: rtl/lsu_agen_pkg.sv
// Package: shared field positions and the decoded control record for the
// load/store address generator. Assumes a 32-bit instruction word.
package lsu_agen_pkg;
    localparam int INSTR_W  = 32;
    localparam int REG_W    = 4;
    localparam int IMM_W    = 12;

    // Field positions that the decoder depends on
    localparam int POS_CLS_HI  = 27;
    localparam int POS_CLS_LO  = 26;
    localparam int POS_REGFORM = 25;
    localparam int POS_PRE     = 24;
    localparam int POS_UP      = 23;
    localparam int POS_BYTE    = 22;
    localparam int POS_WB      = 21;
    localparam int POS_LOAD    = 20;
    localparam int POS_RN_LO   = 16;
    localparam int POS_RM_LO   = 0;
    localparam int POS_SHBIT   = 4;

    localparam logic [1:0]       CLS_LDST = 2'b01;
    localparam logic [REG_W-1:0] PC_IDX   = '1;

    typedef struct packed {
        logic             hit;
        logic             reg_form;
        logic             pre;
        logic             up;
        logic             byte_acc;
        logic             wb_bit;
        logic             load;
        logic [REG_W-1:0] rn;
        logic [REG_W-1:0] rm;
        logic [IMM_W-1:0] imm;
    } agen_ctl_t;
endpackage

// File: rtl/lsu_agen_decode.sv
// Module: lsu_agen_decode
// Splits the instruction word into the control record. Purely
// combinational. Assumes the caller gates the result with its own valid.
module lsu_agen_decode
    import lsu_agen_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output agen_ctl_t          ctl
);
    logic cls_ok;
    logic media_space;

    // Recognise the word/byte load-store class and exclude the space where
    // bit 25 and bit 4 are both set
    always_comb begin
        cls_ok      = (instr[POS_CLS_HI:POS_CLS_LO] == CLS_LDST);
        media_space = instr[POS_REGFORM] & instr[POS_SHBIT];
    end

    // Pull out each field into the record
    always_comb begin
        ctl.hit      = cls_ok & ~media_space;
        ctl.reg_form = instr[POS_REGFORM];
        ctl.pre      = instr[POS_PRE];
        ctl.up       = instr[POS_UP];
        ctl.byte_acc = instr[POS_BYTE];
        ctl.wb_bit   = instr[POS_WB];
        ctl.load     = instr[POS_LOAD];
        ctl.rn       = instr[POS_RN_LO +: REG_W];
        ctl.rm       = instr[POS_RM_LO +: REG_W];
        ctl.imm      = instr[IMM_W-1:0];
    end
endmodule

// File: rtl/lsu_agen_addsub.sv
// Module: lsu_agen_addsub
// Modulo-2^W add or subtract of the offset to or from the base.
// SHARED = 1 uses one adder with an inverted operand and a carry-in.
// SHARED = 0 builds separate add and subtract paths and a final mux.
module lsu_agen_addsub #(
    parameter int W      = 32,
    parameter bit SHARED = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         up,
    output logic [W-1:0] sum
);
    generate
        if (SHARED) begin : g_shared
            logic [W-1:0] b_eff;
            logic [W-1:0] cin;
            // Invert the offset and add one for subtraction
            always_comb begin
                b_eff = b ^ {W{~up}};
                cin   = {{(W-1){1'b0}}, ~up};
                sum   = a + b_eff + cin;
            end
        end else begin : g_split
            logic [W-1:0] s_add;
            logic [W-1:0] s_sub;
            // Two independent paths and a late select
            always_comb begin
                s_add = a + b;
                s_sub = a - b;
                sum   = up ? s_add : s_sub;
            end
        end
    endgenerate
endmodule

// File: rtl/lsu_agen_select.sv
// Module: lsu_agen_select
// Picks the offset source and computes the sum. Chooses the access address
// and the writeback value by indexing form. Derives the translated and
// undefined-result flags. Combinational. Assumes W >= the immediate width.
module lsu_agen_select
    import lsu_agen_pkg::*;
#(
    parameter int W      = 32,
    parameter bit SHARED = 1'b1
) (
    input  agen_ctl_t    ctl,
    input  logic [W-1:0] base,
    input  logic [W-1:0] idx,
    input  logic         cond_pass,
    input  logic         valid,
    output logic [W-1:0] addr,
    output logic         wb_en,
    output logic [W-1:0] wb_val,
    output logic         user_xlat,
    output logic         unpred
);
    localparam int PAD_W = W - IMM_W;

    logic [W-1:0] offset;
    logic [W-1:0] sum;
    logic         wb_form;
    logic         rn_pc;
    logic         rm_pc;
    logic         rn_eq_rm;

    // Offset source: zero-extended immediate or pre-shifted index
    always_comb begin
        offset = ctl.reg_form ? idx : {{PAD_W{1'b0}}, ctl.imm};
    end

    lsu_agen_addsub #(.W(W), .SHARED(SHARED)) u_addsub (
        .a   (base),
        .b   (offset),
        .up  (ctl.up),
        .sum (sum)
    );

    // Indexing form decides which value addresses memory and whether
    // the base is updated
    always_comb begin
        wb_form = ~ctl.pre | ctl.wb_bit;
        addr    = ctl.pre ? sum : base;
        wb_val  = sum;
        wb_en   = valid & ctl.hit & cond_pass & wb_form;
    end

    // Translated-access and undefined-operand flags
    always_comb begin
        rn_pc     = (ctl.rn == PC_IDX);
        rm_pc     = (ctl.rm == PC_IDX);
        rn_eq_rm  = (ctl.rn == ctl.rm);
        user_xlat = ctl.hit & ~ctl.pre & ctl.wb_bit;
        unpred    = ctl.hit & ((wb_form & rn_pc)
                             | (ctl.reg_form & rm_pc)
                             | (ctl.reg_form & wb_form & rn_eq_rm));
    end
endmodule

// File: rtl/lsu_agen.sv
// Module: lsu_agen (top)
// Address generator for word and unsigned-byte loads and stores. Decodes
// the instruction, computes address and writeback, and registers all
// results once. Assumes the index input is already scaled by an external
// shifter and that the condition is evaluated elsewhere. Synchronous,
// active-low reset clears every output.
module lsu_agen
    import lsu_agen_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] base_val,
    input  logic [DATA_W-1:0] index_val,
    input  logic              cond_pass,
    output logic              out_valid,
    output logic              hit,
    output logic [DATA_W-1:0] addr,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_val,
    output logic              is_load,
    output logic              is_byte,
    output logic              user_xlat,
    output logic              unpred
);
    agen_ctl_t         ctl;
    logic [DATA_W-1:0] c_addr;
    logic [DATA_W-1:0] c_wbv;
    logic              c_wben;
    logic              c_user;
    logic              c_unp;

    lsu_agen_decode u_dec (
        .instr (instr),
        .ctl   (ctl)
    );

    lsu_agen_select #(.W(DATA_W), .SHARED(SHARED_ADDER)) u_sel (
        .ctl       (ctl),
        .base      (base_val),
        .idx       (index_val),
        .cond_pass (cond_pass),
        .valid     (in_valid),
        .addr      (c_addr),
        .wb_en     (c_wben),
        .wb_val    (c_wbv),
        .user_xlat (c_user),
        .unpred    (c_unp)
    );

    // Valid and writeback strobe: cleared on reset and on idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wb_en     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wb_en     <= c_wben;
        end
    end

    // Result payload: captured on a valid cycle, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit       <= 1'b0;
            addr      <= '0;
            wb_val    <= '0;
            is_load   <= 1'b0;
            is_byte   <= 1'b0;
            user_xlat <= 1'b0;
            unpred    <= 1'b0;
        end else if (in_valid) begin
            hit       <= ctl.hit;
            addr      <= c_addr;
            wb_val    <= c_wbv;
            is_load   <= ctl.load;
            is_byte   <= ctl.byte_acc;
            user_xlat <= c_user;
            unpred    <= c_unp;
        end
    end
endmodule

// File: rtl/lsu_agen_chk.sv
// Module: lsu_agen_chk
// Checker bound to lsu_agen. Relates the registered outputs to the inputs
// of the previous cycle.
module lsu_agen_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       instr,
    input logic [DATA_W-1:0] base_val,
    input logic              cond_pass,
    input logic              out_valid,
    input logic [DATA_W-1:0] addr,
    input logic              wb_en,
    input logic              user_xlat,
    input logic              unpred
);
    logic recog;
    always_comb recog = (instr[27:26] == 2'b01) && !(instr[25] && instr[4]);

    p_offset_no_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && recog && instr[24] && !instr[21]) |=> !wb_en);

    p_post_base_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && recog && !instr[24]) |=> (addr == $past(base_val)));

    p_imm_sub_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && recog && instr[24] && !instr[23] && !instr[25])
        |=> (addr == $past(base_val) - DATA_W'($past(instr[11:0]))));

    p_cond_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cond_pass) |=> !wb_en);

    p_user_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && recog && cond_pass && !instr[24] && instr[21])
        |=> (wb_en && user_xlat));

    p_valid_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wb_en));

    p_foreign_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !recog) |=> (!wb_en && !user_xlat && !unpred));
endmodule

bind lsu_agen lsu_agen_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .base_val  (base_val),
    .cond_pass (cond_pass),
    .out_valid (out_valid),
    .addr      (addr),
    .wb_en     (wb_en),
    .user_xlat (user_xlat),
    .unpred    (unpred)
);

// File: tb/tb_lsu_agen.sv
`timescale 1ns/1ps
module tb_lsu_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic        cond_pass = 1'b0;
    logic        out_valid, hit, wb_en, is_load, is_byte, user_xlat, unpred;
    logic [31:0] addr, wb_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lsu_agen #(.DATA_W(32), .SHARED_ADDER(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .base_val(base_val), .index_val(index_val), .cond_pass(cond_pass),
        .out_valid(out_valid), .hit(hit), .addr(addr), .wb_en(wb_en),
        .wb_val(wb_val), .is_load(is_load), .is_byte(is_byte),
        .user_xlat(user_xlat), .unpred(unpred)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Build an instruction from its fields
    function automatic logic [31:0] mk(input bit regf, input bit p, input bit u,
                                       input bit b, input bit w, input bit l,
                                       input logic [3:0] rn, input logic [3:0] rm,
                                       input logic [11:0] imm);
        logic [31:0] v;
        v = {4'hE, 2'b01, regf, p, u, b, w, l, rn, 4'h2, imm};
        if (regf) v[3:0] = rm;
        if (regf) v[4] = 1'b0;
        return v;
    endfunction

    // Apply one vector at a falling edge, check results one edge later
    task automatic apply(input logic [31:0] ins, input logic [31:0] bv,
                         input logic [31:0] iv, input bit cp, input bit vld);
        bit e_hit, p, u, w, regf, wbform, e_wb, e_user, e_unp;
        logic [31:0] off, sum, e_addr;
        logic [3:0] rn, rm;
        instr = ins; base_val = bv; index_val = iv; cond_pass = cp; in_valid = vld;
        e_hit = (ins[27:26] == 2'b01) && !(ins[25] && ins[4]);
        regf = ins[25]; p = ins[24]; u = ins[23]; w = ins[21];
        rn = ins[19:16]; rm = ins[3:0];
        off = regf ? iv : {20'b0, ins[11:0]};
        sum = u ? bv + off : bv - off;
        wbform = !p || w;
        e_addr = p ? sum : bv;
        e_wb = vld && e_hit && cp && wbform;
        e_user = e_hit && !p && w;
        e_unp = e_hit && ((wbform && rn == 4'hF) || (regf && rm == 4'hF)
                          || (regf && wbform && rn == rm));
        @(negedge clk);
        chk("R12", "out_valid", 32'(out_valid), 32'(vld));
        chk("R5", "wb_en", 32'(wb_en), 32'(e_wb));
        if (vld) begin
            chk("R13", "hit", 32'(hit), 32'(e_hit));
            chk("R8", "user_xlat", 32'(user_xlat), 32'(e_user));
            chk("R9", "unpred", 32'(unpred), 32'(e_unp));
            if (e_hit) begin
                chk(p ? "R3" : "R4", "addr", addr, e_addr);
                if (e_wb) chk("R1", "wb_val", wb_val, sum);
                chk("R6", "is_load", 32'(is_load), 32'(ins[20]));
                chk("R6", "is_byte", 32'(is_byte), 32'(ins[22]));
            end
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        // R11: outputs cleared under reset
        chk("R11", "out_valid", 32'(out_valid), 0);
        chk("R11", "addr", addr, 0);
        chk("R11", "wb_en", 32'(wb_en), 0);
        chk("R11", "wb_val", wb_val, 0);
        chk("R11", "flags", {28'b0, is_load, is_byte, user_xlat, unpred}, 0);
        rst_n = 1'b1;

        // R1/R7: immediate add and subtract in offset form (R2)
        apply(mk(0,1,1,0,0,1,4'h1,4'h0,12'h123), 32'h1000, 32'hDEAD, 1, 1);
        chk("R2", "addr_imm_add", addr, 32'h1123);
        chk("R2", "no_wb", 32'(wb_en), 0);
        apply(mk(0,1,0,0,0,0,4'h1,4'h0,12'hFFF), 32'h2000, 32'h0, 1, 1);
        chk("R1", "addr_imm_sub", addr, 32'h1001);
        // R7: register offset uses index_val, not the immediate bits
        apply(mk(1,1,1,1,0,1,4'h2,4'h3,12'h0), 32'h100, 32'h40, 1, 1);
        chk("R7", "addr_reg", addr, 32'h140);
        // R3: pre-index writeback, and with condition failing (R5)
        apply(mk(0,1,1,0,1,1,4'h4,4'h0,12'h8), 32'h500, 32'h0, 1, 1);
        chk("R3", "wb_val", wb_val, 32'h508);
        apply(mk(0,1,1,0,1,1,4'h4,4'h0,12'h8), 32'h500, 32'h0, 0, 1);
        chk("R5", "wb_en_fail", 32'(wb_en), 0);
        // R4: post-index uses base, writes sum
        apply(mk(1,0,0,0,0,0,4'h5,4'h6,12'h0), 32'h800, 32'h10, 1, 1);
        chk("R4", "addr_base", addr, 32'h800);
        chk("R4", "wb_post", wb_val, 32'h7F0);
        // R8: translated post-index still writes back
        apply(mk(0,0,1,1,1,1,4'h7,4'h0,12'h4), 32'h900, 32'h0, 1, 1);
        chk("R8", "user", 32'(user_xlat), 1);
        chk("R8", "wb_en", 32'(wb_en), 1);
        // R10: wrap on add and subtract
        apply(mk(0,1,1,0,0,1,4'h1,4'h0,12'h020), 32'hFFFF_FFF0, 32'h0, 1, 1);
        chk("R10", "wrap_add", addr, 32'h10);
        apply(mk(0,1,0,0,0,1,4'h1,4'h0,12'h008), 32'h5, 32'h0, 1, 1);
        chk("R10", "wrap_sub", addr, 32'hFFFF_FFFD);
        // R9: each undefined-result clause and a clean offset-form PC base
        apply(mk(0,0,1,0,0,1,4'hF,4'h0,12'h4), 32'h0, 32'h0, 1, 1);
        chk("R9", "rn_pc_wb", 32'(unpred), 1);
        apply(mk(0,1,1,0,0,1,4'hF,4'h0,12'h4), 32'h0, 32'h0, 1, 1);
        chk("R9", "rn_pc_offset", 32'(unpred), 0);
        apply(mk(1,1,1,0,0,1,4'h1,4'hF,12'h0), 32'h0, 32'h0, 1, 1);
        chk("R9", "rm_pc", 32'(unpred), 1);
        apply(mk(1,1,1,0,1,1,4'h3,4'h3,12'h0), 32'h0, 32'h0, 1, 1);
        chk("R9", "rn_eq_rm", 32'(unpred), 1);
        // R13: foreign instruction classes
        apply(32'hE080_1002, 32'h0, 32'h0, 1, 1);
        chk("R13", "hit_off", 32'(hit), 0);
        apply(32'hE6B0_1F13, 32'h0, 32'h0, 1, 1);
        chk("R13", "media_wb", 32'(wb_en), 0);
        // R12: idle cycle
        apply(mk(0,0,1,0,0,1,4'h1,4'h0,12'h4), 32'h0, 32'h0, 1, 0);
        chk("R12", "idle_valid", 32'(out_valid), 0);

        // Constrained random mix
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] ins;
            logic [3:0] rn, rm;
            rn = ($urandom % 4 == 0) ? 4'hF : 4'($urandom);
            rm = ($urandom % 4 == 0) ? rn : 4'($urandom);
            ins = mk(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom), rn, rm, 12'($urandom));
            if ($urandom % 10 == 0) ins = $urandom;
            apply(ins, $urandom, $urandom, 1'($urandom), ($urandom % 8) != 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule